// File: doc/BRIEF.md
# MDIO Management Register Interface

This block puts a serial management bus master behind two small registers. A control register names the PHY, the PHY register and the direction of the transfer. A data register holds the value to write or the value that was read. A single write to the control register, made while the engine is idle, starts one clause-22 management frame on MDC/MDIO. The busy flag in the control register stays high until the frame ends.

Software uses busy as an interlock on both sides of a transfer. It first waits for busy to clear. For a write, it loads the data register and then writes the control register. For a read, it writes the control register, polls busy until it drops, and then reads the data register. While busy is high, the block discards writes to either register.

MDC runs at the system clock divided by `2*DIV_HALF`. MDIO changes only while MDC is low. Read data is captured on the rising edge of MDC. During the turnaround and data bits of a read, the master releases MDIO through a separate output-enable pin.

Top module: `mdio_mgmt_regs`

## Requirements
- R1: After reset, both registers read zero, MDC is low and the MDIO output enable is low.
- R2: The control register has this layout: bits [4:0] are the PHY register number, bits [9:5] are the PHY address, bit 10 is the direction (1 = write, 0 = read), and bit 15 is busy. Bits [14:11] read as zero. Once the engine is idle, the fields read back as they were written.
- R3: A control write made while idle makes busy read 1 in the next cycle. Busy then stays high for exactly `128*DIV_HALF` cycles (256 by default) and drops after the last data bit.
- R4: A control write made while busy is ignored. The latched fields do not change, only one frame of 64 MDC periods is sent, and no second frame follows.
- R5: A data-register write made while busy is ignored. The register keeps its value, and a write frame in progress carries the value that was loaded before the start.
- R6: A write frame is sent MSB first: 32 ones, start 01, opcode 01, PHY address, register number, turnaround 10 and the 16 data bits. The output enable is high for all 64 bits.
- R7: A read frame drives 32 ones, start 01, opcode 10, PHY address and register number, which is 46 bits. It then holds the output enable low for the last 18 bits (the turnaround and the data).
- R8: During a read, MDIO input bits 48 to 63 of the frame are sampled on the rising edge of MDC, MSB first. The 16-bit result is readable from the data register once busy is clear.
- R9: MDC has a period of `2*DIV_HALF` clocks while busy and is low while idle. MDIO does not change while MDC is high.
- R10: A data-register write made while idle is read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control, 1 = data |
| wr_data | input | 16 | Write value |
| rd_sel | input | 1 | Read target: 0 = control, 1 = data |
| rd_data | output | 16 | Combinational read value of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
Busy is due in the first cycle after the control-write edge. The bench drives that write from a falling clock edge and reads busy at the very next falling edge. It then counts falling edges until busy reads 0 and expects exactly `128*DIV_HALF` of them. The frame is captured on each MDC rise, when MDIO has been stable for half an MDC period. Read data is checked only after busy has dropped, because the last bit enters the data register on the final rising edge of MDC.

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs #(
  parameter int DIV_HALF = 2,
  parameter int PHY_W    = 5,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_W = 32 + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int REL_IDX = 32 + 4 + PHY_W + REG_W;
  localparam int SMP_IDX = FRAME_W - DATA_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int DIV_W   = $clog2(DIV_HALF + 1);
  localparam int PAD_W   = DATA_W - 2 - PHY_W - REG_W;

  logic              busy, op_wr, mdc_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] data_q;
  logic [FRAME_W-1:0] sh;
  logic [IDX_W-1:0]  bit_idx;
  logic [DIV_W-1:0]  div_cnt;

  wire ctrl_go  = wr_en && !wr_sel && !busy;
  wire data_go  = wr_en &&  wr_sel && !busy;
  wire dir_wr   = wr_data[PHY_W+REG_W];
  wire half_end = div_cnt == DIV_W'(DIV_HALF - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op_wr   <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      data_q  <= '0;
      sh      <= '0;
      bit_idx <= '0;
      div_cnt <= '0;
      mdc_q   <= 1'b0;
    end else if (ctrl_go) begin
      busy    <= 1'b1;
      op_wr   <= dir_wr;
      phy_q   <= wr_data[REG_W +: PHY_W];
      reg_q   <= wr_data[REG_W-1:0];
      sh      <= {{32{1'b1}}, 2'b01, dir_wr ? 2'b01 : 2'b10,
                  wr_data[REG_W +: PHY_W], wr_data[REG_W-1:0], 2'b10, data_q};
      bit_idx <= '0;
      div_cnt <= '0;
      mdc_q   <= 1'b0;
    end else if (data_go) begin
      data_q <= wr_data;
    end else if (busy) begin
      if (half_end) begin
        div_cnt <= '0;
        if (!mdc_q) begin
          mdc_q <= 1'b1;
          if (!op_wr && bit_idx >= IDX_W'(SMP_IDX))
            data_q <= {data_q[DATA_W-2:0], mdio_i};
        end else begin
          mdc_q <= 1'b0;
          sh    <= {sh[FRAME_W-2:0], 1'b0};
          if (bit_idx == IDX_W'(FRAME_W - 1)) busy <= 1'b0;
          else bit_idx <= bit_idx + 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = sh[FRAME_W-1];
  assign mdio_oe = busy && (op_wr || bit_idx < IDX_W'(REL_IDX));
  assign rd_data = rd_sel ? data_q : {busy, {PAD_W{1'b0}}, op_wr, phy_q, reg_q};
endmodule

// File: rtl/mdio_mgmt_regs_chk.sv
module mdio_mgmt_regs_chk #(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic              busy,
  input logic              op_wr,
  input logic [PHY_W-1:0]  phy_q,
  input logic [REG_W-1:0]  reg_q,
  input logic [DATA_W-1:0] data_q,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R9
  AST_BUSY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && !busy) |=> busy); // R3
  AST_CMD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_wr) && $stable(phy_q) && $stable(reg_q))); // R4
  AST_WDATA_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && op_wr) |-> $stable(data_q)); // R5
  AST_MDIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o)); // R9
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_wr) |-> mdio_oe); // R6
endmodule

bind mdio_mgmt_regs mdio_mgmt_regs_chk #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .busy(busy),
  .op_wr(op_wr), .phy_q(phy_q), .reg_q(reg_q), .data_q(data_q),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_regs_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_regs_bench;
  localparam int DIV_HALF = 2;
  localparam int NV = 4;
  // {dir_wr, phy, reg, write data, phy response}
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 5'h1f, 5'h00, 16'hA5C3, 16'h0000},
    {1'b0, 5'h01, 5'h02, 16'h0000, 16'h1234},
    {1'b0, 5'h10, 5'h1f, 16'h0000, 16'h8001},
    {1'b1, 5'h00, 5'h1f, 16'h0001, 16'h0000}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [15:0] wr_data = '0, rd_data;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  int checks = 0, errors = 0, rise_cnt = 0, base = 0;
  logic [63:0] cap_o = '0, cap_oe = '0, resp_frame = '1;
  time last_t = 0, prev_t = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mdio_mgmt_regs #(.DIV_HALF(DIV_HALF)) u_mdio_mgmt_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  assign mdio_i = (rise_cnt - base < 64) ? resp_frame[63 - (rise_cnt - base)] : 1'b1;

  always @(posedge mdc) begin
    cap_o    <= {cap_o[62:0], mdio_o};
    cap_oe   <= {cap_oe[62:0], mdio_oe};
    rise_cnt <= rise_cnt + 1;
    prev_t   <= last_t;
    last_t   <= $time;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic reg_read(input logic sel, output logic [15:0] d);
    rd_sel = sel; #0.5; d = rd_data;
  endtask

  task automatic wait_idle(output int n);
    logic [15:0] v;
    n = 0;
    forever begin
      reg_read(0, v);
      if (!v[15]) break;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] v;
    int n;
    repeat (4) @(negedge clk);
    reg_read(0, v); chk(v == 16'h0, "R1 ctrl", v, 0);
    reg_read(1, v); chk(v == 16'h0, "R1 data", v, 0);
    chk(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic dw; logic [4:0] ph, rg; logic [15:0] wd, rs;
      {dw, ph, rg, wd, rs} = VEC[i];
      base = rise_cnt;
      resp_frame = {48'hFFFF_FFFF_FFFF, rs};
      if (dw) reg_write(1, wd);
      reg_write(0, {5'b0, dw, ph, rg});
      reg_read(0, v); chk(v[15] == 1'b1, "R3 busy next cycle", v, 16'h8000);
      wait_idle(n);
      chk(n == 128*DIV_HALF, "R3 busy length", n, 128*DIV_HALF);
      chk(rise_cnt - base == 64, "R9 mdc periods", rise_cnt - base, 64);
      reg_read(0, v); chk(v == {5'b0, dw, ph, rg}, "R2 ctrl readback", v, {5'b0, dw, ph, rg});
      if (dw) begin
        chk(cap_o == {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, wd}, "R6 write frame",
            cap_o, {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, wd});
        chk(cap_oe == '1, "R6 enable", cap_oe, '1);
      end else begin
        chk(cap_o[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, ph, rg}, "R7 read header",
            cap_o[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, ph, rg});
        chk(cap_oe == {{46{1'b1}}, 18'h0}, "R7 release", cap_oe, {{46{1'b1}}, 18'h0});
        reg_read(1, v); chk(v == rs, "R8 read data", v, rs);
      end
    end
    chk(last_t - prev_t == 2*DIV_HALF*4, "R9 mdc period ns", last_t - prev_t, 2*DIV_HALF*4);

    reg_write(1, 16'h5A5A);
    reg_read(1, v); chk(v == 16'h5A5A, "R10 data readback", v, 16'h5A5A);

    reg_write(1, 16'hBEEF);
    base = rise_cnt;
    reg_write(0, {5'b0, 1'b1, 5'h03, 5'h04});
    repeat (20) @(negedge clk);
    reg_write(0, {5'b0, 1'b0, 5'h07, 5'h09});
    reg_write(1, 16'h1111);
    reg_read(0, v); chk(v == {1'b1, 4'b0, 1'b1, 5'h03, 5'h04}, "R4 ctrl while busy", v, {1'b1, 4'b0, 1'b1, 5'h03, 5'h04});
    reg_read(1, v); chk(v == 16'hBEEF, "R5 data while busy", v, 16'hBEEF);
    wait_idle(n);
    reg_read(0, v); chk(v == {5'b0, 1'b1, 5'h03, 5'h04}, "R4 ctrl after", v, {5'b0, 1'b1, 5'h03, 5'h04});
    chk(cap_o[15:0] == 16'hBEEF, "R5 frame data", cap_o[15:0], 16'hBEEF);
    repeat (40) @(negedge clk);
    chk(rise_cnt - base == 64, "R4 single frame", rise_cnt - base, 64);
    reg_read(0, v); chk(!v[15] && !mdc, "R4 stays idle", {v[15], mdc}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule